// File: doc/BRIEF.md
# Shader Instruction Hazard Checker

This block watches the instruction stream of a dual-issue SIMD shader core, one 64-bit word per cycle, and flags scheduling mistakes that the core itself does not interlock against. A start pulse marks the beginning of a program, and a fragment flag tells the checker whether the program is a fragment shader. Each broken rule sets its own violation bit. That bit stays set until the next start pulse. The checker also records the zero-based index of the first instruction that broke any rule.

The checker decodes only the fields that its rules need. It keeps a small history of the previous instruction's writes and four short countdown windows. These windows cover the slots after a thread end, after an SFU lookup, after a depth write to the tile buffer, and after a write to the TMU no-swap register. Every rule is judged on the instruction that breaks it, and the result appears one cycle after that instruction is presented. The checker never stalls, alters or reorders the stream.

Top module: `shader_hazard_checker`

## Requirements
- R1: Field layout.
  - Signal field: `[63:60]`.
  - Write-swap bit: 44.
  - Add-pipe write address: `[43:38]`.
  - Mul-pipe write address: `[37:32]`.
  - Read address A: `[23:18]`.
  - Read address B: `[17:12]`.
  - Input mux selects: add_a `[11:9]`, add_b `[8:6]`, mul_a `[5:3]`, mul_b `[2:0]`. Values 0 to 5 select r0 to r5, 6 selects file A and 7 selects file B.
  - Signal code 14 marks an immediate load, and 15 marks a branch. Neither of these reads through its read-address or mux fields.
  - Signal code 13 means the B read address holds a small immediate.
  - Write address 39 and read address 39 are no-ops.
- R2: Within the thread-end window, bit 0 is set by any of the following:
  - reading uniforms (read address 32 on either port);
  - reading varyings (read address 35);
  - reading the vertex memory (read addresses 48 to 50);
  - writing the vertex memory (write addresses 48 to 50).
  The window is the instruction with signal code 3 and the two instructions after it.
- R3: Bit 1 is set when an instruction with signal code 3 has either write address below 32, meaning a register-file write.
- R4: Bit 2 is set when any instruction in the thread-end window reads or writes address 14 through either read address or either write address.
- R5: Bit 3 is set when the second instruction after signal code 3 writes address 44, the tile-buffer depth write.
- R6: When the fragment flag is high, bit 4 is set by a scoreboard wait in instruction 0 or 1 of the program. A wait is either of the following:
  - signal code 4;
  - a tile-buffer access: signal codes 7, 8, 9 or 12, or a write to address 44 to 47.
  With the flag low, this rule has no effect.
- R7: Bit 5 is set when the first TMU write of a program lands in the instruction that writes the no-swap register, or in either of the two instructions after it. A TMU write is a write to address 56 to 63. The no-swap register is write address 36. TMU writes after the first never trigger this rule.
- R8: Bit 6 is set when an instruction reads, through read address A or B below 32, the same address in the same file that the previous valid instruction wrote. File assignment follows the write-swap bit:
  - clear: the add pipe writes file A and the mul pipe writes file B;
  - set: the add pipe writes file B and the mul pipe writes file A.
  A gap of one instruction clears the hazard.
- R9: In the two instructions after an SFU write (write address 52 to 55), bit 7 is set by either of the following:
  - a mux select of 4 (r4);
  - an r4 producer: signal code 10 or 11 (TMU read), signal code 7, 8, 9 or 12 (tile-buffer read), or another SFU write.
- R10: A vector rotate is signal code 13 with read address B of 48 or more, and 48 means rotate by r5.
  - Bit 8 is set when a rotate by r5 directly follows a write to r5 (write address 37).
  - Bit 9 is set when a rotate directly follows a write to an accumulator r0 to r3 (write addresses 32 to 35) that mul_a or mul_b selects.
- R11: Bit 10 is set when read address A is 42 (the multisample mask) in either of the two instructions after a write to address 44. A write to address 45 or 46 directly after the depth write is allowed.
- R12: Bit 11 is set when one instruction performs more than one of the following access classes:
  - TMU write;
  - TMU read;
  - tile-buffer write (address 44 to 47);
  - tile-buffer read (signal code 7, 8 or 12);
  - combined colour read and write (signal code 9);
  - SFU write;
  - mutex read (read address 51);
  - semaphore access (signal code 14 with bits `[59:57]` equal to 4).
  Two TMU write addresses in one instruction count as a single class.
- R13: Reporting rules:
  - Violation bits and the first-violation index appear one cycle after the offending instruction and stay set until a start pulse clears them.
  - An instruction presented in the same cycle as the start pulse is instruction 0 of the new program.
  - The first index is captured once per program and then held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-of-program pulse; clears all history and results |
| frag_i | input | 1 | High while the program is a fragment shader |
| valid_i | input | 1 | An instruction is presented this cycle |
| instr_i | input | 64 | Instruction word |
| viol_o | output | 12 | Sticky violation bit for each rule |
| first_valid_o | output | 1 | A violation has been captured in this program |
| first_idx_o | output | 8 | Index of the first violating instruction |

## Verification
Every result is registered once, so each violation bit and the first index are due exactly one cycle after the offending instruction is clocked in. For a window rule, that offending instruction is the later one that breaks the rule, not the one that opened the window. The bench presents each instruction half a cycle before the capturing edge and reads the outputs at the following falling edge. As a result, every check lands in the due cycle, and no check depends on process order at the edge. The window rules are swept over distances just inside and just outside their limits, and each sweep point runs as its own program so that no history carries over between points.

// File: rtl/shc_pkg.sv
package shc_pkg;
  localparam int INSTR_W   = 64;
  localparam int NUM_RULES = 12;
  localparam int NUM_PERIPH = 8;
  localparam int WIN_SLOTS = 2;
  localparam int NUM_WIN   = 4;

  // rule bit positions
  localparam int RB_END_IO   = 0;
  localparam int RB_END_RF   = 1;
  localparam int RB_END_A14  = 2;
  localparam int RB_END_Z    = 3;
  localparam int RB_EARLY    = 4;
  localparam int RB_NOSWAP   = 5;
  localparam int RB_RAW      = 6;
  localparam int RB_SFU_R4   = 7;
  localparam int RB_ROT_R5   = 8;
  localparam int RB_ROT_ACC  = 9;
  localparam int RB_MSMASK   = 10;
  localparam int RB_PERIPH   = 11;

  // window slots
  localparam int WN_END = 0;
  localparam int WN_SFU = 1;
  localparam int WN_ZW  = 2;
  localparam int WN_NSW = 3;

  // signal codes
  localparam logic [3:0] SG_END    = 4'd3;
  localparam logic [3:0] SG_WAIT   = 4'd4;
  localparam logic [3:0] SG_COVLD  = 4'd7;
  localparam logic [3:0] SG_COLLD  = 4'd8;
  localparam logic [3:0] SG_COLEND = 4'd9;
  localparam logic [3:0] SG_TMU0   = 4'd10;
  localparam logic [3:0] SG_TMU1   = 4'd11;
  localparam logic [3:0] SG_ALPHA  = 4'd12;
  localparam logic [3:0] SG_SIMM   = 4'd13;
  localparam logic [3:0] SG_LDI    = 4'd14;
  localparam logic [3:0] SG_BRANCH = 4'd15;

  // address codes
  localparam logic [5:0] AD_RF_TOP  = 6'd32;
  localparam logic [5:0] AD_ACC0    = 6'd32;
  localparam logic [5:0] AD_UNIF    = 6'd32;
  localparam logic [5:0] AD_VARY    = 6'd35;
  localparam logic [5:0] AD_NOSWAP  = 6'd36;
  localparam logic [5:0] AD_R5      = 6'd37;
  localparam logic [5:0] AD_MSMASK  = 6'd42;
  localparam logic [5:0] AD_TLB_Z   = 6'd44;
  localparam logic [5:0] AD_TLB_LO  = 6'd44;
  localparam logic [5:0] AD_TLB_HI  = 6'd47;
  localparam logic [5:0] AD_VPM_LO  = 6'd48;
  localparam logic [5:0] AD_VPM_HI  = 6'd50;
  localparam logic [5:0] AD_MUTEX   = 6'd51;
  localparam logic [5:0] AD_SFU_LO  = 6'd52;
  localparam logic [5:0] AD_SFU_HI  = 6'd55;
  localparam logic [5:0] AD_TMU_LO  = 6'd56;
  localparam logic [5:0] AD_RSV14   = 6'd14;
  localparam logic [5:0] AD_ROT_LO  = 6'd48;
  localparam logic [2:0] SEM_TAG    = 3'd4;

  typedef struct packed {
    logic       is_end;
    logic       sig_wait;
    logic       tile_acc;
    logic       wr_a_v;
    logic [4:0] wr_a_addr;
    logic       wr_b_v;
    logic [4:0] wr_b_addr;
    logic       wr_r5;
    logic [3:0] wr_acc;
    logic       rd_a_v;
    logic [4:0] rd_a_addr;
    logic       rd_b_v;
    logic [4:0] rd_b_addr;
    logic       uni_var;
    logic       vpm_acc;
    logic       addr14;
    logic       tlbz_wr;
    logic       noswap_wr;
    logic       tmu_wr;
    logic       sfu_wr;
    logic       r4_read;
    logic       r4_prod;
    logic       rot_r5;
    logic [3:0] rot_acc;
    logic       ms_read;
    logic [NUM_PERIPH-1:0] periph;
  } shc_info_t;

  typedef struct packed {
    logic       a_v;
    logic [4:0] a_addr;
    logic       b_v;
    logic [4:0] b_addr;
    logic       r5;
    logic [3:0] acc;
  } shc_prev_t;
endpackage

// File: rtl/shc_decode.sv
module shc_decode
  import shc_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output shc_info_t          info_o
);
  localparam int NUM_MUX = 4;
  localparam int MUX_W   = 3;

  logic [3:0] sig;
  logic       ws;
  logic [5:0] wa, wm, ra, rb, waddr_a, waddr_b;
  logic       alu, simm, rb_addr;
  logic [NUM_MUX-1:0] mux_r4;
  logic [MUX_W-1:0]   mux_sel [NUM_MUX];
  logic       tmu_rd, tlb_rd, tlb_rw, tlb_wr, mutex_rd, sem;
  logic       unused_bits;

  assign sig = instr_i[63:60];
  assign ws  = instr_i[44];
  assign wa  = instr_i[43:38];
  assign wm  = instr_i[37:32];
  assign ra  = instr_i[23:18];
  assign rb  = instr_i[17:12];
  assign unused_bits = ^{instr_i[56:45], instr_i[31:24]};

  genvar k;
  generate
    for (k = 0; k < NUM_MUX; k++) begin : g_mux
      assign mux_sel[k] = instr_i[MUX_W*k +: MUX_W];
      assign mux_r4[k]  = (mux_sel[k] == 3'd4);
    end
  endgenerate

  always_comb begin
    alu     = (sig != SG_LDI) && (sig != SG_BRANCH);
    simm    = (sig == SG_SIMM);
    rb_addr = alu && !simm;
    waddr_a = ws ? wm : wa;
    waddr_b = ws ? wa : wm;

    tmu_rd   = (sig == SG_TMU0) || (sig == SG_TMU1);
    tlb_rd   = (sig == SG_COVLD) || (sig == SG_COLLD) || (sig == SG_ALPHA);
    tlb_rw   = (sig == SG_COLEND);
    tlb_wr   = ((wa >= AD_TLB_LO) && (wa <= AD_TLB_HI)) ||
               ((wm >= AD_TLB_LO) && (wm <= AD_TLB_HI));
    mutex_rd = (alu && (ra == AD_MUTEX)) || (rb_addr && (rb == AD_MUTEX));
    sem      = (sig == SG_LDI) && (instr_i[59:57] == SEM_TAG);

    info_o = '0;
    info_o.is_end    = (sig == SG_END);
    info_o.sig_wait  = (sig == SG_WAIT);
    info_o.tile_acc  = tlb_rd || tlb_rw || tlb_wr;
    info_o.wr_a_v    = (waddr_a < AD_RF_TOP);
    info_o.wr_a_addr = waddr_a[4:0];
    info_o.wr_b_v    = (waddr_b < AD_RF_TOP);
    info_o.wr_b_addr = waddr_b[4:0];
    info_o.wr_r5     = (wa == AD_R5) || (wm == AD_R5);
    for (int n = 0; n < 4; n++) begin
      info_o.wr_acc[n]  = (wa == AD_ACC0 + 6'(n)) || (wm == AD_ACC0 + 6'(n));
      info_o.rot_acc[n] = simm && (rb >= AD_ROT_LO) &&
                          ((mux_sel[1] == 3'(n)) || (mux_sel[0] == 3'(n)));
    end
    info_o.rd_a_v    = alu && (ra < AD_RF_TOP);
    info_o.rd_a_addr = ra[4:0];
    info_o.rd_b_v    = rb_addr && (rb < AD_RF_TOP);
    info_o.rd_b_addr = rb[4:0];
    info_o.uni_var   = (alu && ((ra == AD_UNIF) || (ra == AD_VARY))) ||
                       (rb_addr && ((rb == AD_UNIF) || (rb == AD_VARY)));
    info_o.vpm_acc   = (alu && (ra >= AD_VPM_LO) && (ra <= AD_VPM_HI)) ||
                       (rb_addr && (rb >= AD_VPM_LO) && (rb <= AD_VPM_HI)) ||
                       ((wa >= AD_VPM_LO) && (wa <= AD_VPM_HI)) ||
                       ((wm >= AD_VPM_LO) && (wm <= AD_VPM_HI));
    info_o.addr14    = (alu && (ra == AD_RSV14)) || (rb_addr && (rb == AD_RSV14)) ||
                       (wa == AD_RSV14) || (wm == AD_RSV14);
    info_o.tlbz_wr   = (wa == AD_TLB_Z) || (wm == AD_TLB_Z);
    info_o.noswap_wr = (wa == AD_NOSWAP) || (wm == AD_NOSWAP);
    info_o.tmu_wr    = (wa >= AD_TMU_LO) || (wm >= AD_TMU_LO);
    info_o.sfu_wr    = ((wa >= AD_SFU_LO) && (wa <= AD_SFU_HI)) ||
                       ((wm >= AD_SFU_LO) && (wm <= AD_SFU_HI));
    info_o.r4_read   = alu && (|mux_r4);
    info_o.r4_prod   = tmu_rd || tlb_rd || tlb_rw || info_o.sfu_wr;
    info_o.rot_r5    = simm && (rb == AD_ROT_LO);
    info_o.ms_read   = alu && (ra == AD_MSMASK);
    info_o.periph    = {sem, mutex_rd, info_o.sfu_wr, tlb_rw, tlb_rd, tlb_wr,
                        tmu_rd, info_o.tmu_wr};
  end
endmodule

// File: rtl/shc_countdown.sv
module shc_countdown #(
  parameter int LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic adv_i,
  input  logic load_i,
  output logic active_o,
  output logic last_o
);
  localparam int CNT_W = $clog2(LEN + 1);

  logic [CNT_W-1:0] cnt_q, cnt_eff, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_eff = clr_i ? '0 : cnt_q;
    cnt_en  = clr_i || adv_i;
    cnt_d   = cnt_eff;
    if (adv_i) begin
      if (load_i)            cnt_d = CNT_W'(LEN);
      else if (cnt_eff != 0) cnt_d = cnt_eff - 1'b1;
    end
  end

  assign active_o = (cnt_eff != '0);
  assign last_o   = (cnt_eff == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/shc_prev.sv
module shc_prev
  import shc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr_i,
  input  logic      adv_i,
  input  shc_prev_t cur_i,
  output shc_prev_t prev_o
);
  shc_prev_t rec_q, rec_d;
  logic      rec_en;

  always_comb begin
    prev_o = clr_i ? '0 : rec_q;
    rec_en = clr_i || adv_i;
    rec_d  = adv_i ? cur_i : prev_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rec_q <= '0;
    else if (rec_en) rec_q <= rec_d;
  end
endmodule

// File: rtl/shader_hazard_checker.sv
module shader_hazard_checker
  import shc_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 frag_i,
  input  logic                 valid_i,
  input  logic [INSTR_W-1:0]   instr_i,
  output logic [NUM_RULES-1:0] viol_o,
  output logic                 first_valid_o,
  output logic [IDX_W-1:0]     first_idx_o
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;
  localparam int PC_W = $clog2(NUM_PERIPH + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  shc_info_t info;
  shc_decode u_dec (.instr_i(instr_i), .info_o(info));

  // windows opened by thread end, SFU write, depth write, no-swap write
  logic [NUM_WIN-1:0] win_load, win_act, win_last;
  assign win_load[WN_END] = info.is_end;
  assign win_load[WN_SFU] = info.sfu_wr;
  assign win_load[WN_ZW]  = info.tlbz_wr;
  assign win_load[WN_NSW] = info.noswap_wr;

  genvar w;
  generate
    for (w = 0; w < NUM_WIN; w++) begin : g_win
      shc_countdown #(.LEN(WIN_SLOTS)) u_cd (
        .clk(clk), .rst_n(rst_core_n), .clr_i(start_i), .adv_i(valid_i),
        .load_i(win_load[w]), .active_o(win_act[w]), .last_o(win_last[w]));
    end
  endgenerate

  shc_prev_t cur_wr, prev_wr;
  always_comb begin
    cur_wr.a_v    = info.wr_a_v;
    cur_wr.a_addr = info.wr_a_addr;
    cur_wr.b_v    = info.wr_b_v;
    cur_wr.b_addr = info.wr_b_addr;
    cur_wr.r5     = info.wr_r5;
    cur_wr.acc    = info.wr_acc;
  end

  shc_prev u_prev (
    .clk(clk), .rst_n(rst_core_n), .clr_i(start_i), .adv_i(valid_i),
    .cur_i(cur_wr), .prev_o(prev_wr));

  // program state
  logic [IDX_W-1:0]     idx_q, idx_eff, idx_d;
  logic                 tmu_done_q, tmu_done_eff, tmu_done_d;
  logic [NUM_RULES-1:0] viol_q, viol_d, hits;
  logic                 first_v_q, first_v_eff, first_v_d;
  logic [IDX_W-1:0]     first_idx_q, first_idx_d;
  logic [PC_W-1:0]      periph_cnt;
  logic                 in_end, any_hit, st_en;

  always_comb begin
    idx_eff      = start_i ? '0 : idx_q;
    tmu_done_eff = start_i ? 1'b0 : tmu_done_q;
    first_v_eff  = start_i ? 1'b0 : first_v_q;
    in_end       = info.is_end || win_act[WN_END];

    periph_cnt = '0;
    for (int p = 0; p < NUM_PERIPH; p++) periph_cnt = periph_cnt + PC_W'(info.periph[p]);

    hits = '0;
    hits[RB_END_IO]  = in_end && (info.uni_var || info.vpm_acc);
    hits[RB_END_RF]  = info.is_end && (info.wr_a_v || info.wr_b_v);
    hits[RB_END_A14] = in_end && info.addr14;
    hits[RB_END_Z]   = win_last[WN_END] && info.tlbz_wr;
    hits[RB_EARLY]   = frag_i && (idx_eff < IDX_W'(2)) && (info.sig_wait || info.tile_acc);
    hits[RB_NOSWAP]  = info.tmu_wr && !tmu_done_eff && (info.noswap_wr || win_act[WN_NSW]);
    hits[RB_RAW]     = (info.rd_a_v && prev_wr.a_v && (info.rd_a_addr == prev_wr.a_addr)) ||
                       (info.rd_b_v && prev_wr.b_v && (info.rd_b_addr == prev_wr.b_addr));
    hits[RB_SFU_R4]  = win_act[WN_SFU] && (info.r4_read || info.r4_prod);
    hits[RB_ROT_R5]  = info.rot_r5 && prev_wr.r5;
    hits[RB_ROT_ACC] = |(info.rot_acc & prev_wr.acc);
    hits[RB_MSMASK]  = win_act[WN_ZW] && info.ms_read;
    hits[RB_PERIPH]  = (periph_cnt > PC_W'(1));

    any_hit = valid_i && (|hits);
    st_en   = start_i || valid_i;

    idx_d       = idx_eff;
    tmu_done_d  = tmu_done_eff;
    viol_d      = start_i ? '0 : viol_q;
    first_v_d   = first_v_eff | any_hit;
    first_idx_d = start_i ? '0 : first_idx_q;
    if (valid_i) begin
      idx_d      = (idx_eff == IDX_MAX) ? IDX_MAX : idx_eff + 1'b1;
      tmu_done_d = tmu_done_eff | info.tmu_wr;
      viol_d     = viol_d | hits;
    end
    if (any_hit && !first_v_eff) first_idx_d = idx_eff;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      idx_q       <= '0;
      tmu_done_q  <= 1'b0;
      viol_q      <= '0;
      first_v_q   <= 1'b0;
      first_idx_q <= '0;
    end else if (st_en) begin
      idx_q       <= idx_d;
      tmu_done_q  <= tmu_done_d;
      viol_q      <= viol_d;
      first_v_q   <= first_v_d;
      first_idx_q <= first_idx_d;
    end
  end

  assign viol_o        = viol_q;
  assign first_valid_o = first_v_q;
  assign first_idx_o   = first_idx_q;
endmodule

// File: rtl/shc_checker.sv
module shc_checker
  import shc_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start_i,
  input logic                 valid_i,
  input logic [INSTR_W-1:0]   instr_i,
  input logic [NUM_RULES-1:0] viol_o,
  input logic                 first_valid_o,
  input logic [IDX_W-1:0]     first_idx_o
);
  logic unused_chk;
  assign unused_chk = ^{instr_i[59:44], instr_i[37:0]};

  p_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ((viol_o & $past(viol_o)) == $past(viol_o)));

  p_first_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (first_valid_o && !start_i) |=> (first_valid_o && $stable(first_idx_o)));

  p_first_flag_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_o != '0) |-> first_valid_o);

  p_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !valid_i) |=> ((viol_o == '0) && !first_valid_o));

  p_end_regfile_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && instr_i[63:60] == 4'd3 && instr_i[43:38] < 6'd32) |=> viol_o[1]);

  p_periph_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && instr_i[63:60] == 4'd10 && instr_i[43:38] >= 6'd56) |=> viol_o[11]);
endmodule

bind shader_hazard_checker shc_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .start_i(start_i), .valid_i(valid_i),
  .instr_i(instr_i), .viol_o(viol_o), .first_valid_o(first_valid_o),
  .first_idx_o(first_idx_o));

// File: tb/shader_hazard_checker_tb_top.sv
module shader_hazard_checker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, frag_i, valid_i;
  logic [63:0] instr_i;
  logic [11:0] viol_o;
  logic        first_valid_o;
  logic [IDX_W-1:0] first_idx_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shader_hazard_checker #(.IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .frag_i(frag_i),
    .valid_i(valid_i), .instr_i(instr_i), .viol_o(viol_o),
    .first_valid_o(first_valid_o), .first_idx_o(first_idx_o));

  function automatic logic [63:0] mk(input int sig, input int ws, input int wa,
                                     input int wm, input int ra, input int rb,
                                     input int mx);
    logic [63:0] r;
    r = '0;
    r[63:60] = sig[3:0];
    r[44]    = ws[0];
    r[43:38] = wa[5:0];
    r[37:32] = wm[5:0];
    r[23:18] = ra[5:0];
    r[17:12] = rb[5:0];
    r[11:0]  = mx[11:0];
    return r;
  endfunction

  function automatic logic [63:0] nop();
    return mk(1, 0, 39, 39, 39, 39, 0);
  endfunction

  function automatic logic [63:0] as_end(input logic [63:0] x);
    logic [63:0] r;
    r = x;
    r[63:60] = 4'd3;
    return r;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic new_prog(input logic frag);
    start_i = 1'b1; frag_i = frag; valid_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic issue(input logic [63:0] x);
    instr_i = x; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0; instr_i = nop();
  endtask

  task automatic pad(input int n);
    for (int j = 0; j < n; j++) issue(nop());
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] off;
    rst_n = 1'b0; start_i = 1'b0; frag_i = 1'b0; valid_i = 1'b0; instr_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk("R13 reset viol", int'(viol_o), 0);
    chk("R13 reset first", int'(first_valid_o), 0);

    // R3 thread end writing a register file
    new_prog(0); issue(mk(3, 0, 5, 39, 39, 39, 0));
    chk("R3 end add write", int'(viol_o), 2);
    new_prog(0); issue(mk(3, 0, 39, 7, 39, 39, 0));
    chk("R3 end mul write", int'(viol_o), 2);
    new_prog(0); issue(mk(3, 0, 39, 39, 39, 39, 0));
    chk("R3 end no write", int'(viol_o), 0);

    // R2 uniform, varying and vertex-memory access in the end window
    for (int k = 0; k < 3; k++) begin
      for (int o = 0; o < 4; o++) begin
        off = (k == 0) ? mk(1, 0, 39, 39, 32, 39, 0) :
              (k == 1) ? mk(1, 0, 39, 39, 39, 35, 0) : mk(1, 0, 48, 39, 39, 39, 0);
        new_prog(0);
        if (o == 0) issue(as_end(off));
        else begin issue(as_end(nop())); pad(o - 1); issue(off); end
        chk($sformatf("R2 kind %0d offset %0d", k, o), int'(viol_o), (o <= 2) ? 1 : 0);
      end
    end

    // R4 address 14 in the end window
    for (int o = 0; o < 4; o++) begin
      off = mk(1, 0, 39, 39, 14, 39, 0);
      new_prog(0);
      if (o == 0) issue(as_end(off));
      else begin issue(as_end(nop())); pad(o - 1); issue(off); end
      chk($sformatf("R4 offset %0d", o), int'(viol_o), (o <= 2) ? 4 : 0);
    end

    // R5 depth write only forbidden in the final delay slot
    for (int o = 0; o < 4; o++) begin
      off = mk(1, 0, 44, 39, 39, 39, 0);
      new_prog(0);
      if (o == 0) issue(as_end(off));
      else begin issue(as_end(nop())); pad(o - 1); issue(off); end
      chk($sformatf("R5 offset %0d", o), int'(viol_o), (o == 2) ? 8 : 0);
    end

    // R6 early scoreboard wait, explicit and implicit, fragment flag swept
    for (int f = 0; f < 2; f++) begin
      for (int k = 0; k < 2; k++) begin
        for (int p = 0; p < 4; p++) begin
          new_prog(f[0]);
          pad(p);
          issue((k == 0) ? mk(4, 0, 39, 39, 39, 39, 0) : mk(1, 0, 45, 39, 39, 39, 0));
          chk($sformatf("R6 frag %0d kind %0d pos %0d", f, k, p), int'(viol_o),
              (f == 1 && p < 2) ? 16 : 0);
        end
      end
    end

    // R7 no-swap distance to the first TMU write
    for (int d = 0; d < 5; d++) begin
      new_prog(0);
      if (d == 0) issue(mk(1, 0, 36, 56, 39, 39, 0));
      else begin issue(mk(1, 0, 36, 39, 39, 39, 0)); pad(d - 1); issue(mk(1, 0, 39, 56, 39, 39, 0)); end
      chk($sformatf("R7 distance %0d", d), int'(viol_o), (d < 3) ? 32 : 0);
    end
    new_prog(0);
    issue(mk(1, 0, 56, 39, 39, 39, 0));
    issue(mk(1, 0, 36, 39, 39, 39, 0));
    issue(mk(1, 0, 57, 39, 39, 39, 0));
    chk("R7 not first TMU write", int'(viol_o), 0);

    // R8 read after write, write-swap routing
    for (int w = 0; w < 2; w++) begin
      for (int f = 0; f < 2; f++) begin
        new_prog(0);
        issue(mk(1, w, 9, 39, 39, 39, 0));
        issue((f == 0) ? mk(1, 0, 39, 39, 9, 39, 0) : mk(1, 0, 39, 39, 39, 9, 0));
        chk($sformatf("R8 swap %0d file %0d", w, f), int'(viol_o), (w == f) ? 64 : 0);
      end
    end
    new_prog(0);
    issue(mk(1, 1, 39, 9, 39, 39, 0));
    issue(mk(1, 0, 39, 39, 9, 39, 0));
    chk("R1 R8 mul pipe swapped to A", int'(viol_o), 64);
    new_prog(0);
    issue(mk(1, 0, 9, 39, 39, 39, 0)); pad(1);
    issue(mk(1, 0, 39, 39, 9, 39, 0));
    chk("R8 one gap", int'(viol_o), 0);
    new_prog(0);
    issue(mk(1, 0, 9, 39, 39, 39, 0));
    issue(mk(1, 0, 39, 39, 10, 39, 0));
    chk("R8 other address", int'(viol_o), 0);
    new_prog(0);
    issue(mk(1, 0, 9, 39, 39, 39, 0));
    issue(mk(13, 0, 39, 39, 39, 9, 0));
    chk("R1 R8 small immediate not a read", int'(viol_o), 0);

    // R9 r4 use after an SFU write
    for (int k = 0; k < 2; k++) begin
      for (int g = 1; g < 4; g++) begin
        new_prog(0);
        issue(mk(1, 0, 52, 39, 39, 39, 0)); pad(g - 1);
        issue((k == 0) ? mk(1, 0, 39, 39, 39, 39, 4 << 9) : mk(10, 0, 39, 39, 39, 39, 0));
        chk($sformatf("R9 kind %0d gap %0d", k, g), int'(viol_o), (g <= 2) ? 128 : 0);
      end
    end

    // R10 rotate hazards
    new_prog(0);
    issue(mk(1, 0, 37, 39, 39, 39, 0)); issue(mk(13, 0, 39, 39, 39, 48, 0));
    chk("R10 rotate by r5 after r5 write", int'(viol_o), 256);
    new_prog(0);
    issue(mk(1, 0, 37, 39, 39, 39, 0)); issue(mk(13, 0, 39, 39, 39, 51, 0));
    chk("R10 fixed rotate after r5 write", int'(viol_o), 0);
    new_prog(0);
    issue(mk(1, 0, 37, 39, 39, 39, 0)); pad(1); issue(mk(13, 0, 39, 39, 39, 48, 0));
    chk("R10 rotate by r5 with gap", int'(viol_o), 0);
    new_prog(0);
    issue(mk(1, 0, 34, 39, 39, 39, 0)); issue(mk(13, 0, 39, 39, 39, 50, 2 << 3));
    chk("R1 R10 rotate written accumulator", int'(viol_o), 512);
    new_prog(0);
    issue(mk(1, 0, 33, 39, 39, 39, 0)); issue(mk(13, 0, 39, 39, 39, 50, 2 << 3));
    chk("R10 rotate other accumulator", int'(viol_o), 0);

    // R11 multisample mask after depth write
    for (int g = 1; g < 4; g++) begin
      new_prog(0);
      issue(mk(1, 0, 44, 39, 39, 39, 0)); pad(g - 1);
      issue(mk(1, 0, 39, 39, 42, 39, 0));
      chk($sformatf("R11 gap %0d", g), int'(viol_o), (g <= 2) ? 1024 : 0);
    end
    new_prog(0);
    issue(mk(1, 0, 44, 39, 39, 39, 0)); issue(mk(1, 0, 45, 39, 39, 39, 0));
    chk("R11 colour after depth", int'(viol_o), 0);

    // R12 peripheral exclusivity
    new_prog(0); issue(mk(1, 0, 56, 52, 39, 39, 0));
    chk("R12 tmu write + sfu", int'(viol_o), 2048);
    new_prog(0); issue(mk(1, 0, 56, 57, 39, 39, 0));
    chk("R12 two tmu writes", int'(viol_o), 0);
    new_prog(0); issue(mk(10, 0, 45, 39, 39, 39, 0));
    chk("R12 tmu read + tile write", int'(viol_o), 2048);
    new_prog(0); issue(mk(9, 0, 39, 39, 39, 39, 0));
    chk("R12 combined colour alone", int'(viol_o), 0);
    new_prog(0); issue(mk(9, 0, 45, 39, 39, 39, 0));
    chk("R12 combined colour + tile write", int'(viol_o), 2048);
    new_prog(0); issue(mk(1, 0, 52, 39, 51, 39, 0));
    chk("R12 mutex + sfu", int'(viol_o), 2048);
    new_prog(0); issue(mk(14, 0, 56, 39, 39, 39, 0) | (64'h4 << 57));
    chk("R12 semaphore + tmu write", int'(viol_o), 2048);
    new_prog(0); issue(mk(14, 0, 56, 39, 39, 39, 0));
    chk("R12 plain load + tmu write", int'(viol_o), 0);

    // R13 first index, stickiness, start coincident with an instruction
    new_prog(0);
    pad(3);
    issue(mk(1, 0, 9, 39, 39, 39, 0));
    issue(mk(1, 0, 39, 39, 9, 39, 0));
    chk("R13 first flag", int'(first_valid_o), 1);
    chk("R13 first index", int'(first_idx_o), 4);
    pad(1);
    chk("R13 sticky", int'(viol_o), 64);
    issue(mk(3, 0, 3, 39, 39, 39, 0));
    chk("R13 second violation adds", int'(viol_o), 66);
    chk("R13 index held", int'(first_idx_o), 4);
    new_prog(0);
    chk("R13 start clears viol", int'(viol_o), 0);
    chk("R13 start clears first", int'(first_valid_o), 0);
    start_i = 1'b1; valid_i = 1'b1; instr_i = mk(3, 0, 3, 39, 39, 39, 0);
    @(negedge clk);
    start_i = 1'b0; valid_i = 1'b0; instr_i = nop();
    chk("R13 start with instruction", int'(viol_o), 2);
    chk("R13 start instruction index", int'(first_idx_o), 0);
    pad(2);
    chk("R13 index zero held", int'(first_idx_o), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule